// File: doc/BRIEF.md
# Masked Vector Element Sequencer

This block walks the element positions of one vector operation on a register file of 16 vectors, each with 64 elements of 64 bits. After a start pulse it presents one element index per cycle, counting up from zero. The index count is cut off by a saturating length register. Each presented index carries an enable that says whether the datapath should act on that element. The enable is either always true or, when masking is selected, follows the matching bit of a 64-bit mask register, with a polarity bit that chooses whether a set or a clear bit means "act".

The same mask register is the target of vector compares. When the operation is a compare, the datapath returns one boolean per presented element on `cmp_bit`, aligned with that element's cycle. The block writes it into the mask bit of that element, but only for elements that are enabled. The length and mask registers can also be loaded directly through their write ports, and their contents are visible on `vlen_out` and `mask_out`. Arithmetic, memory access and decode sit outside the block. For longword and single-precision work, the datapath uses only the low 32 bits of each element, and the sequencing is the same for them.

Top module: `vmask_elem_seq`

## Requirements
- R1: After reset, `elem_valid`, `elem_last` and `done` are 0, `vlen_out` is 0 and `mask_out` is all zeros.
- R2: A length write stores `len_wdata` unchanged when it is 64 or less and stores 64 when it is larger; `vlen_out` shows the stored value from the cycle after the write.
- R3: A start with stored length L greater than 0 presents indices 0, 1, … L-1 on consecutive cycles starting the cycle after start, with `elem_valid` high. `elem_last` is high only with index L-1, and `done` is high for one cycle, the cycle after the last index.
- R4: A start with stored length 0 presents no element, and `done` is high in the cycle after start.
- R5: When the start's mask-enable bit is 0, every presented element has `elem_en` = 1, whatever the mask holds.
- R6: When the start's mask-enable bit is 1, element i has `elem_en` = 1 exactly when mask bit i equals the start's polarity bit. With polarity 1 a set bit means act; with polarity 0 a clear bit means act.
- R7: In a compare operation (start's compare bit = 1), each element presented with `elem_en` = 1 writes `cmp_bit` of its cycle into mask bit i at the end of that cycle. Mask bits of elements not enabled, and of positions at or above the length, keep their values.
- R8: When a mask-port write and a compare write fall in the same cycle, the mask takes `mask_wdata`, except that the current element's bit takes the compare result. Elements presented later use the new mask contents for their enable.
- R9: A start that arrives while elements are being presented is ignored, and the mask-enable, polarity and compare bits stay as latched at the accepted start. A length write during the operation does not change the number of elements presented, and it shows on `vlen_out` afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted while no element is being presented |
| start_mask_en | input | 1 | Mask-enable control bit, latched at start |
| start_mask_true | input | 1 | Mask polarity: the bit value that means "act" |
| start_cmp | input | 1 | Operation is a compare that writes the mask |
| len_we | input | 1 | Length register write strobe |
| len_wdata | input | 8 | Length value to write (saturated to 64) |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 64 | Mask value to write |
| cmp_bit | input | 1 | Compare result for the element presented this cycle |
| elem_valid | output | 1 | An element index is presented |
| elem_idx | output | 6 | Presented element index |
| elem_en | output | 1 | Presented element is to be processed |
| elem_last | output | 1 | Presented element is the final one |
| done | output | 1 | One-cycle pulse ending the operation |
| vlen_out | output | 7 | Stored length |
| mask_out | output | 64 | Stored mask |

## Verification
The mask register can be written by its port and by a compare result in the same cycle. The bench provokes this by pulsing `mask_we` during a masked compare while an element is presented. It then checks that the current element's bit holds the compare result and every other bit holds the port value. It also checks that the enables of the elements that follow are judged against the freshly loaded mask. A second overlap lands a start pulse and a length write in the middle of an operation. That overlap is judged by the unchanged index run and by the new length appearing on `vlen_out` only afterwards.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  typedef struct packed {
    logic mask_en;
    logic mask_true;
    logic cmp;
  } seq_ctrl_t;
endpackage

// File: rtl/vseq_len_reg.sv
module vseq_len_reg #(
  parameter int NELEM    = 64,
  parameter int LEN_IN_W = 8,
  parameter int LEN_W    = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [LEN_IN_W-1:0] wdata,
  output logic [LEN_W-1:0]    len_q
);
  localparam logic [LEN_IN_W-1:0] MAX_IN  = LEN_IN_W'(NELEM);
  localparam logic [LEN_W-1:0]    MAX_LEN = LEN_W'(NELEM);

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= '0;
    end else if (we) begin
      len_q <= (wdata > MAX_IN) ? MAX_LEN : wdata[LEN_W-1:0];
    end
  end

  assert_len_sat_R2: assert property (@(posedge clk) disable iff (rst)
    len_q <= MAX_LEN);
  assert_len_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(len_q));
endmodule

// File: rtl/vseq_mask_reg.sv
module vseq_mask_reg #(
  parameter int NELEM = 64,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             port_we,
  input  logic [NELEM-1:0] port_wdata,
  input  logic             cmp_we,
  input  logic [IDX_W-1:0] cmp_idx,
  input  logic             cmp_bit,
  output logic [NELEM-1:0] mask_q
);
  localparam logic [NELEM-1:0] ONE = NELEM'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
    end else begin
      if (port_we) mask_q <= port_wdata;
      if (cmp_we)  mask_q[cmp_idx] <= cmp_bit;
    end
  end

  logic [NELEM-1:0] others;
  always_comb others = ~(ONE << cmp_idx);

  assert_cmp_keep_R7: assert property (@(posedge clk) disable iff (rst)
    (cmp_we && !port_we) |=> ((mask_q ^ $past(mask_q)) & $past(others)) == '0);
  assert_cmp_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (cmp_we && port_we) |=> (mask_q[$past(cmp_idx)] == $past(cmp_bit)));
endmodule

// File: rtl/vseq_issue.sv
module vseq_issue
  import vseq_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  seq_ctrl_t        ctrl_in,
  input  logic [LEN_W-1:0] len,
  output logic             valid_q,
  output logic [IDX_W-1:0] idx_q,
  output logic             last_q,
  output logic             done_q,
  output seq_ctrl_t        ctrl_q
);
  logic [IDX_W-1:0] top_q;
  logic [IDX_W-1:0] idx_nx;

  always_comb idx_nx = idx_q + IDX_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
      last_q  <= 1'b0;
      done_q  <= 1'b0;
      ctrl_q  <= '0;
      top_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!valid_q) begin
        if (start) begin
          ctrl_q <= ctrl_in;
          if (len == '0) begin
            done_q <= 1'b1;
          end else begin
            valid_q <= 1'b1;
            idx_q   <= '0;
            last_q  <= (len == LEN_W'(1));
            top_q   <= IDX_W'(len - LEN_W'(1));
          end
        end
      end else if (last_q) begin
        valid_q <= 1'b0;
        last_q  <= 1'b0;
        done_q  <= 1'b1;
      end else begin
        idx_q  <= idx_nx;
        last_q <= (idx_nx == top_q);
      end
    end
  end

  assert_step_R3: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !last_q) |=> (valid_q && idx_q == $past(idx_q) + IDX_W'(1)));
  assert_last_done_R3: assert property (@(posedge clk) disable iff (rst)
    last_q |=> (done_q && !valid_q));
  assert_last_valid_R3: assert property (@(posedge clk) disable iff (rst)
    last_q |-> valid_q);
  assert_zero_len_R4: assert property (@(posedge clk) disable iff (rst)
    (!valid_q && start && len == '0) |=> (done_q && !valid_q));
  assert_ctrl_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !last_q) |=> $stable(ctrl_q));
endmodule

// File: rtl/vmask_elem_seq.sv
module vmask_elem_seq
  import vseq_pkg::*;
#(
  parameter  int NELEM    = 64,
  parameter  int LEN_IN_W = 8,
  localparam int IDX_W    = $clog2(NELEM),
  localparam int LEN_W    = $clog2(NELEM + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                start_mask_en,
  input  logic                start_mask_true,
  input  logic                start_cmp,
  input  logic                len_we,
  input  logic [LEN_IN_W-1:0] len_wdata,
  input  logic                mask_we,
  input  logic [NELEM-1:0]    mask_wdata,
  input  logic                cmp_bit,
  output logic                elem_valid,
  output logic [IDX_W-1:0]    elem_idx,
  output logic                elem_en,
  output logic                elem_last,
  output logic                done,
  output logic [LEN_W-1:0]    vlen_out,
  output logic [NELEM-1:0]    mask_out
);
  seq_ctrl_t        ctrl_in, ctrl_q;
  logic [LEN_W-1:0] len_q;
  logic [NELEM-1:0] mask_q;
  logic             cmp_we;

  always_comb begin
    ctrl_in.mask_en   = start_mask_en;
    ctrl_in.mask_true = start_mask_true;
    ctrl_in.cmp       = start_cmp;
  end

  vseq_len_reg #(.NELEM(NELEM), .LEN_IN_W(LEN_IN_W), .LEN_W(LEN_W)) u_len (
    .clk(clk), .rst(rst), .we(len_we), .wdata(len_wdata), .len_q(len_q));

  vseq_issue #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_issue (
    .clk(clk), .rst(rst), .start(start), .ctrl_in(ctrl_in), .len(len_q),
    .valid_q(elem_valid), .idx_q(elem_idx), .last_q(elem_last),
    .done_q(done), .ctrl_q(ctrl_q));

  always_comb begin
    elem_en = elem_valid &&
              (!ctrl_q.mask_en || (mask_q[elem_idx] == ctrl_q.mask_true));
    cmp_we  = elem_en && ctrl_q.cmp;
  end

  vseq_mask_reg #(.NELEM(NELEM), .IDX_W(IDX_W)) u_mask (
    .clk(clk), .rst(rst), .port_we(mask_we), .port_wdata(mask_wdata),
    .cmp_we(cmp_we), .cmp_idx(elem_idx), .cmp_bit(cmp_bit), .mask_q(mask_q));

  assign vlen_out = len_q;
  assign mask_out = mask_q;
endmodule

// File: tb/tb_vmask_elem_seq.sv
module tb_vmask_elem_seq;
  logic        clk = 1'b0;
  logic        rst;
  logic        start, start_mask_en, start_mask_true, start_cmp;
  logic        len_we, mask_we, cmp_bit;
  logic [7:0]  len_wdata;
  logic [63:0] mask_wdata;
  logic        elem_valid, elem_en, elem_last, done;
  logic [5:0]  elem_idx;
  logic [6:0]  vlen_out;
  logic [63:0] mask_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  vmask_elem_seq dut (
    .clk(clk), .rst(rst), .start(start), .start_mask_en(start_mask_en),
    .start_mask_true(start_mask_true), .start_cmp(start_cmp),
    .len_we(len_we), .len_wdata(len_wdata), .mask_we(mask_we),
    .mask_wdata(mask_wdata), .cmp_bit(cmp_bit), .elem_valid(elem_valid),
    .elem_idx(elem_idx), .elem_en(elem_en), .elem_last(elem_last),
    .done(done), .vlen_out(vlen_out), .mask_out(mask_out));

  typedef struct packed {
    logic [7:0]  len;
    logic        men;
    logic        pol;
    logic        cmp;
    logic [63:0] init;
    logic [63:0] pat;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t TBL [NV] = '{
    '{8'd64,  1'b0, 1'b1, 1'b0, 64'hF0F0_F0F0_F0F0_F0F0, 64'h0},
    '{8'd10,  1'b1, 1'b1, 1'b0, 64'h0000_0000_0000_0255, 64'h0},
    '{8'd10,  1'b1, 1'b0, 1'b0, 64'h0000_0000_0000_0255, 64'h0},
    '{8'd200, 1'b1, 1'b1, 1'b0, 64'hAAAA_AAAA_AAAA_AAAA, 64'h0},
    '{8'd65,  1'b1, 1'b0, 1'b0, 64'h8000_0000_0000_0001, 64'h0},
    '{8'd16,  1'b0, 1'b1, 1'b1, 64'hFFFF_0000_0000_0000, 64'h0000_0000_0000_9C3A},
    '{8'd20,  1'b1, 1'b1, 1'b1, 64'h0000_0000_000F_0F0F, 64'h0000_0000_0005_5AA5},
    '{8'd1,   1'b0, 1'b0, 1'b0, 64'h0,                  64'h0}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // One full operation; wr_at/dist_at = -1 disables those disturbances.
  task automatic run_op(input logic [7:0] len, input logic men, input logic pol,
                        input logic cmp, input logic [63:0] init,
                        input logic [63:0] pat, input int wr_at,
                        input logic [63:0] wr_val, input int dist_at);
    int L;
    logic [63:0] model;
    L = (len > 8'd64) ? 64 : int'(len);
    len_we = 1'b1; len_wdata = len; mask_we = 1'b1; mask_wdata = init;
    @(negedge clk);
    len_we = 1'b0; mask_we = 1'b0;
    chk(vlen_out == 7'(L), "R2 length", 64'(vlen_out), 64'(L));
    chk(mask_out == init, "R8 port load", mask_out, init);
    model = init;
    start = 1'b1; start_mask_en = men; start_mask_true = pol; start_cmp = cmp;
    @(negedge clk);
    start = 1'b0;
    if (L == 0) begin
      chk(done && !elem_valid, "R4 zero length done", {62'd0, done, elem_valid}, 64'h2);
      @(negedge clk);
      chk(!done && !elem_valid, "R4 no elements", {62'd0, done, elem_valid}, 64'h0);
      return;
    end
    for (int k = 0; k < L; k++) begin
      logic exp_en;
      exp_en = !men || (model[k] == pol);
      chk(elem_valid && elem_idx == 6'(k), "R3 index order", 64'(elem_idx), 64'(k));
      chk(elem_last == (k == L - 1), "R3 last flag", 64'(elem_last), 64'(k == L - 1));
      chk(!done, "R3 no early done", 64'(done), 64'h0);
      if (men) chk(elem_en == exp_en, "R6 masked enable", 64'(elem_en), 64'(exp_en));
      else     chk(elem_en == 1'b1, "R5 unmasked enable", 64'(elem_en), 64'h1);
      cmp_bit = pat[k];
      if (k == wr_at) begin mask_we = 1'b1; mask_wdata = wr_val; end
      if (k == dist_at) begin
        start = 1'b1; start_mask_en = ~men; start_mask_true = ~pol; start_cmp = ~cmp;
        len_we = 1'b1; len_wdata = 8'd3;
      end
      if (k == wr_at) model = wr_val;
      if (cmp && exp_en) model[k] = pat[k];
      @(negedge clk);
      mask_we = 1'b0; start = 1'b0; len_we = 1'b0; cmp_bit = 1'b0;
    end
    chk(done && !elem_valid, "R3 done after last", {62'd0, done, elem_valid}, 64'h2);
    chk(mask_out == model, "R7 mask after op", mask_out, model);
    if (dist_at >= 0)
      chk(vlen_out == 7'd3, "R9 length write visible after", 64'(vlen_out), 64'd3);
    @(negedge clk);
    chk(!done, "R3 done single cycle", 64'(done), 64'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    rst = 1'b1; start = 0; start_mask_en = 0; start_mask_true = 0; start_cmp = 0;
    len_we = 0; len_wdata = 0; mask_we = 0; mask_wdata = 0; cmp_bit = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!elem_valid && !elem_last && !done, "R1 reset outputs",
        {61'd0, elem_valid, elem_last, done}, 64'h0);
    chk(vlen_out == '0, "R1 reset length", 64'(vlen_out), 64'h0);
    chk(mask_out == '0, "R1 reset mask", mask_out, 64'h0);

    for (int i = 0; i < NV; i++)
      run_op(TBL[i].len, TBL[i].men, TBL[i].pol, TBL[i].cmp, TBL[i].init,
             TBL[i].pat, -1, 64'h0, -1);

    // R4 length zero, with masking and compare requested
    run_op(8'd0, 1'b1, 1'b1, 1'b1, 64'h1234_5678_9ABC_DEF0, 64'hFFFF, -1, 64'h0, -1);
    chk(mask_out == 64'h1234_5678_9ABC_DEF0, "R7 zero length keeps mask",
        mask_out, 64'h1234_5678_9ABC_DEF0);
    // R2 exact boundary
    run_op(8'd64, 1'b0, 1'b1, 1'b0, 64'h0, 64'h0, -1, 64'h0, -1);
    // R8 port write and compare write in the same cycle, masked compare
    run_op(8'd12, 1'b1, 1'b1, 1'b1, 64'h0000_0000_0000_00FF,
           64'h0000_0000_0000_0A5A, 3, 64'h0000_0000_0000_0F3C, -1);
    // R8 with masking off: every element writes
    run_op(8'd8, 1'b0, 1'b0, 1'b1, 64'h0, 64'h0000_0000_0000_00C3, 5,
           64'hFFFF_FFFF_FFFF_FFFF, -1);
    // R9 start and length write while issuing are ignored by the running op
    run_op(8'd9, 1'b1, 1'b0, 1'b1, 64'h0000_0000_0000_0F0F,
           64'h0000_0000_0000_01F5, -1, 64'h0, 2);
    run_op(8'd5, 1'b0, 1'b1, 1'b0, 64'h0, 64'h0, -1, 64'h0, 4);
    summary();
  end
endmodule